// File: doc/BRIEF.md
# Bus Watchpoint and Breakpoint Comparator Unit

This block observes three processor buses while the processor runs: the instruction-fetch address, the load/store address and the load/store data. Eight programmable comparators each test one bus against a programmed value using one of four relational conditions. The comparators are grouped in pairs, and each pair is combined into one result. The pair results are turned into six watchpoint pulses.

Each watchpoint also feeds an event counter. An enabled counter raises a one-cycle breakpoint pulse on every Nth watchpoint event. The unit only observes the buses. It has no handshake on them, so it never delays a transfer, and every valid transfer is examined. Software programs the unit through a word-addressed register port with a registered read path.

Top module: `dbg_watch_unit`

## Requirements
- R1: When `rst` is high on a clock edge, the following are cleared: `wp_o`, `bp_o`, `cfg_rdata`, every comparator value, every control field, every pair mode and every counter register. After reset no watchpoint fires.
- R2: A write sets `cfg_we` with `cfg_addr` and `cfg_wdata`. `cfg_rdata` shows the register selected by `cfg_addr` one clock later. The map is as follows:
  - 0x00–0x07: comparator values, full width.
  - 0x08–0x0F: comparator control, 3 bits.
  - 0x10–0x13: pair modes, 2 bits.
  - 0x18–0x1D: counter registers. The preset count is in bits 15:0 and the enable bit is bit 16.
  - Unused bits and unmapped addresses (0x14–0x17, 0x1E, 0x1F) read as 0.
- R3: Control bits 1:0 select the condition: 0 is bus == value, 1 is bus != value, 2 is bus < value, 3 is bus > value.
- R4: The bus assignment is fixed. Comparators 0–3 test `if_addr`, comparators 4–5 test `ls_addr`, and comparators 6–7 test `ls_data`.
- R5: Address comparisons are always unsigned, and control bit 2 has no effect on comparators 0–5. On comparators 6–7, control bit 2 set makes the less-than and greater-than tests two's-complement signed.
- R6: Pair p is formed from comparators 2p and 2p+1. The pair mode selects how they are combined: 0 gives no match, 1 uses comparator 2p alone, 2 uses the AND of both, and 3 uses the OR of both. Watchpoints 0–3 are the results of pairs 0–3.
- R7: Watchpoint 4 is pair 2 AND pair 3, so it needs a load/store address match and a data match on the same transfer. Watchpoint 5 is pair 2 OR pair 3.
- R8: A comparator matches only while its bus's valid input (`if_valid` or `ls_valid`) is high. Without a valid transfer, no watchpoint is raised.
- R9: `wp_o` is high during the cycle that follows each clock edge sampling a matching valid transfer. Back-to-back transfers give one pulse per transfer, with none lost.
- R10: Suppose counter k is enabled with preset N. Then `bp_o[k]` pulses together with the Nth `wp_o[k]` event and every Nth event after it. A preset of 0 acts as 1.
- R11: A counter whose enable bit is clear never raises `bp_o`. Writing a counter register restarts its event count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's `cfg_addr` |
| if_valid | input | 1 | Instruction-fetch transfer valid |
| if_addr | input | 32 | Instruction-fetch address |
| ls_valid | input | 1 | Load/store transfer valid |
| ls_addr | input | 32 | Load/store address |
| ls_data | input | 32 | Load/store data |
| wp_o | output | 6 | Watchpoint pulses |
| bp_o | output | 6 | Breakpoint pulses |

## Verification
The assertions check four relations on every cycle:
- A breakpoint never appears without its own watchpoint.
- Watchpoints 0–1 need a valid fetch, and watchpoints 2–5 need a valid load/store, on the edge before.
- Watchpoint 4 always implies watchpoint 5.
- The outputs are quiet after reset.

Only the directed scenarios can show the rest:
- the truth of each relational condition at its boundary value;
- the signed versus unsigned ordering;
- range and exclusion matching formed by pairs;
- the Nth-event counting, its reload and its restart on a write.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int NUM_CMP  = 8;
  localparam int NUM_PAIR = NUM_CMP / 2;
  localparam int NUM_WP   = 6;
  localparam int IF_CMPS  = 4;   // comparators on fetch address
  localparam int LA_CMPS  = 2;   // comparators on load/store address
  localparam int AW       = 5;   // register word address width
  localparam int CTL_W    = 3;

  typedef enum logic [1:0] {
    COND_EQ = 2'd0,
    COND_NE = 2'd1,
    COND_LT = 2'd2,
    COND_GT = 2'd3
  } cond_e;

  typedef enum logic [1:0] {
    PAIR_OFF = 2'd0,
    PAIR_ONE = 2'd1,
    PAIR_AND = 2'd2,
    PAIR_OR  = 2'd3
  } pair_e;
endpackage

// File: rtl/dbg_watch_regs.sv
module dbg_watch_regs
  import dbg_watch_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [NUM_CMP-1:0][DW-1:0] cmp_val,
  output logic [NUM_CMP-1:0][CTL_W-1:0] cmp_ctl,
  output logic [NUM_PAIR-1:0][1:0]   pair_mode,
  output logic [NUM_WP-1:0][CNT_W-1:0] cnt_preset,
  output logic [NUM_WP-1:0]          cnt_en,
  output logic [NUM_WP-1:0]          cnt_clr
);
  localparam logic [1:0] GRP_VAL = 2'd0;
  localparam logic [1:0] GRP_CTL = 2'd1;
  localparam logic [1:0] GRP_MIX = 2'd2;
  localparam logic [1:0] GRP_CNT = 2'd3;

  logic [1:0] grp;
  logic [2:0] idx;
  assign grp = addr[4:3];
  assign idx = addr[2:0];

  always_comb begin
    cnt_clr = '0;
    if (we && grp == GRP_CNT && int'(idx) < NUM_WP)
      cnt_clr[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val    <= '0;
      cmp_ctl    <= '0;
      pair_mode  <= '0;
      cnt_preset <= '0;
      cnt_en     <= '0;
    end else if (we) begin
      case (grp)
        GRP_VAL: cmp_val[idx] <= wdata;
        GRP_CTL: cmp_ctl[idx] <= wdata[CTL_W-1:0];
        GRP_MIX: if (!idx[2]) pair_mode[idx[1:0]] <= wdata[1:0];
        default: if (int'(idx) < NUM_WP) begin
          cnt_preset[idx] <= wdata[CNT_W-1:0];
          cnt_en[idx]     <= wdata[CNT_W];
        end
      endcase
    end
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (grp)
      GRP_VAL: rd_next = cmp_val[idx];
      GRP_CTL: rd_next[CTL_W-1:0] = cmp_ctl[idx];
      GRP_MIX: if (!idx[2]) rd_next[1:0] = pair_mode[idx[1:0]];
      default: if (int'(idx) < NUM_WP) begin
        rd_next[CNT_W-1:0] = cnt_preset[idx];
        rd_next[CNT_W]     = cnt_en[idx];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/dbg_watch_cmp.sv
module dbg_watch_cmp
  import dbg_watch_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit SIGNED_OK = 1'b0
) (
  input  logic             valid,
  input  logic [DW-1:0]    bus,
  input  logic [DW-1:0]    value,
  input  logic [CTL_W-1:0] ctl,
  output logic             hit
);
  logic lt, gt, eq;
  assign eq = (bus == value);

  generate
    if (SIGNED_OK) begin : g_sel
      always_comb begin
        if (ctl[2]) begin
          lt = $signed(bus) < $signed(value);
          gt = $signed(bus) > $signed(value);
        end else begin
          lt = bus < value;
          gt = bus > value;
        end
      end
    end else begin : g_uns
      assign lt = bus < value;
      assign gt = bus > value;
    end
  endgenerate

  always_comb begin
    case (cond_e'(ctl[1:0]))
      COND_EQ: hit = valid & eq;
      COND_NE: hit = valid & ~eq;
      COND_LT: hit = valid & lt;
      default: hit = valid & gt;
    endcase
  end
endmodule

// File: rtl/dbg_watch_comb.sv
module dbg_watch_comb
  import dbg_watch_pkg::*;
(
  input  logic [NUM_CMP-1:0]      hits,
  input  logic [NUM_PAIR-1:0][1:0] pair_mode,
  output logic [NUM_WP-1:0]       wp
);
  logic [NUM_PAIR-1:0] pr;

  generate
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      always_comb begin
        case (pair_e'(pair_mode[p]))
          PAIR_OFF: pr[p] = 1'b0;
          PAIR_ONE: pr[p] = hits[2*p];
          PAIR_AND: pr[p] = hits[2*p] & hits[2*p+1];
          default:  pr[p] = hits[2*p] | hits[2*p+1];
        endcase
      end
    end
  endgenerate

  assign wp[NUM_PAIR-1:0] = pr;
  assign wp[4] = pr[2] & pr[3];
  assign wp[5] = pr[2] | pr[3];
endmodule

// File: rtl/dbg_watch_cnt.sv
module dbg_watch_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] preset,
  input  logic             clr,
  input  logic             evt,
  output logic             bp
);
  logic [CNT_W-1:0] seen;
  logic [CNT_W:0]   nxt;
  logic             last;

  assign nxt  = {1'b0, seen} + 1'b1;
  assign last = (preset == '0) || (nxt >= {1'b0, preset});

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      bp   <= 1'b0;
    end else begin
      bp <= 1'b0;
      if (clr) begin
        seen <= '0;
      end else if (en && evt) begin
        if (last) begin
          seen <= '0;
          bp   <= 1'b1;
        end else begin
          seen <= nxt[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              if_valid,
  input  logic [DW-1:0]     if_addr,
  input  logic              ls_valid,
  input  logic [DW-1:0]     ls_addr,
  input  logic [DW-1:0]     ls_data,
  output logic [NUM_WP-1:0] wp_o,
  output logic [NUM_WP-1:0] bp_o
);
  logic [NUM_CMP-1:0][DW-1:0]      cmp_val;
  logic [NUM_CMP-1:0][CTL_W-1:0]   cmp_ctl;
  logic [NUM_PAIR-1:0][1:0]        pair_mode;
  logic [NUM_WP-1:0][CNT_W-1:0]    cnt_preset;
  logic [NUM_WP-1:0]               cnt_en;
  logic [NUM_WP-1:0]               cnt_clr;
  logic [NUM_CMP-1:0]              hits;
  logic [NUM_WP-1:0]               wp_next;

  dbg_watch_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cmp_val(cmp_val), .cmp_ctl(cmp_ctl),
    .pair_mode(pair_mode), .cnt_preset(cnt_preset), .cnt_en(cnt_en),
    .cnt_clr(cnt_clr)
  );

  generate
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      if (k < IF_CMPS) begin : g_if
        dbg_watch_cmp #(.DW(DW), .SIGNED_OK(1'b0)) u_cmp (
          .valid(if_valid), .bus(if_addr), .value(cmp_val[k]),
          .ctl(cmp_ctl[k]), .hit(hits[k]));
      end else if (k < IF_CMPS + LA_CMPS) begin : g_la
        dbg_watch_cmp #(.DW(DW), .SIGNED_OK(1'b0)) u_cmp (
          .valid(ls_valid), .bus(ls_addr), .value(cmp_val[k]),
          .ctl(cmp_ctl[k]), .hit(hits[k]));
      end else begin : g_ld
        dbg_watch_cmp #(.DW(DW), .SIGNED_OK(1'b1)) u_cmp (
          .valid(ls_valid), .bus(ls_data), .value(cmp_val[k]),
          .ctl(cmp_ctl[k]), .hit(hits[k]));
      end
    end
  endgenerate

  dbg_watch_comb u_comb (
    .hits(hits), .pair_mode(pair_mode), .wp(wp_next)
  );

  always_ff @(posedge clk) begin
    if (rst) wp_o <= '0;
    else     wp_o <= wp_next;
  end

  generate
    for (genvar w = 0; w < NUM_WP; w++) begin : g_cnt
      dbg_watch_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en(cnt_en[w]), .preset(cnt_preset[w]),
        .clr(cnt_clr[w]), .evt(wp_next[w]), .bp(bp_o[w]));
    end
  endgenerate
endmodule

// File: rtl/dbg_watch_unit_chk.sv
module dbg_watch_unit_chk
  import dbg_watch_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              if_valid,
  input logic              ls_valid,
  input logic [NUM_WP-1:0] wp_o,
  input logic [NUM_WP-1:0] bp_o
);
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (wp_o == '0 && bp_o == '0));

  p_bp_with_wp_r10: assert property (@(posedge clk) disable iff (rst)
    (bp_o & ~wp_o) == '0);

  p_fetch_wp_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (wp_o[1:0] != '0) |-> $past(if_valid));

  p_ls_wp_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (wp_o[5:2] != '0) |-> $past(ls_valid));

  p_and_implies_or_r7: assert property (@(posedge clk) disable iff (rst)
    wp_o[4] |-> wp_o[5]);
endmodule

bind dbg_watch_unit dbg_watch_unit_chk u_chk (
  .clk(clk), .rst(rst), .if_valid(if_valid), .ls_valid(ls_valid),
  .wp_o(wp_o), .bp_o(bp_o)
);

// File: tb/dbg_watch_unit_tb.sv
module dbg_watch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        if_valid = 1'b0;
  logic [31:0] if_addr = '0;
  logic        ls_valid = 1'b0;
  logic [31:0] ls_addr = '0;
  logic [31:0] ls_data = '0;
  logic [5:0]  wp_o, bp_o;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dbg_watch_unit u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .if_valid(if_valid),
    .if_addr(if_addr), .ls_valid(ls_valid), .ls_addr(ls_addr),
    .ls_data(ls_data), .wp_o(wp_o), .bp_o(bp_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic ev_if(input logic [31:0] a, input logic v);
    if_valid = v; if_addr = a;
    @(negedge clk);
    if_valid = 1'b0;
  endtask

  task automatic ev_ls(input logic [31:0] a, input logic [31:0] d, input logic v);
    ls_valid = v; ls_addr = a; ls_data = d;
    @(negedge clk);
    ls_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    wr(5'h03, 32'h1234_5678);
    do_reset();
    check("R1 wp_o after reset", {26'b0, wp_o}, 32'h0);
    check("R1 bp_o after reset", {26'b0, bp_o}, 32'h0);
    rd(5'h03, d);
    check("R1 value cleared", d, 32'h0);
    ev_if(32'h0, 1'b1);
    check("R1 no watchpoint after reset", {26'b0, wp_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(5'h03, 32'hDEAD_BEEF); rd(5'h03, d); check("R2 value readback", d, 32'hDEAD_BEEF);
    wr(5'h0E, 32'hFFFF_FFFF); rd(5'h0E, d); check("R2 control 3 bits", d, 32'h7);
    wr(5'h11, 32'hFFFF_FFFF); rd(5'h11, d); check("R2 pair mode 2 bits", d, 32'h3);
    wr(5'h1A, 32'hABCD_2345); rd(5'h1A, d); check("R2 counter reg", d, 32'h0001_2345);
    wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, d); check("R2 unmapped 0x14", d, 32'h0);
    wr(5'h1F, 32'hFFFF_FFFF); rd(5'h1F, d); check("R2 unmapped 0x1F", d, 32'h0);
  endtask

  task automatic t_cond();
    do_reset();
    wr(5'h00, 32'h100); wr(5'h10, 32'h1);
    wr(5'h08, 32'h0);
    ev_if(32'h100, 1'b1); check("R3 EQ hit", {26'b0, wp_o}, 32'h01);
    ev_if(32'h104, 1'b1); check("R3 EQ miss", {26'b0, wp_o}, 32'h00);
    wr(5'h08, 32'h1);
    ev_if(32'h104, 1'b1); check("R3 NE hit", {26'b0, wp_o}, 32'h01);
    ev_if(32'h100, 1'b1); check("R3 NE miss", {26'b0, wp_o}, 32'h00);
    wr(5'h08, 32'h2);
    ev_if(32'h0FF, 1'b1); check("R3 LT hit", {26'b0, wp_o}, 32'h01);
    ev_if(32'h100, 1'b1); check("R3 LT boundary", {26'b0, wp_o}, 32'h00);
    wr(5'h08, 32'h3);
    ev_if(32'h101, 1'b1); check("R3 GT hit", {26'b0, wp_o}, 32'h01);
    ev_if(32'h100, 1'b1); check("R3 GT boundary", {26'b0, wp_o}, 32'h00);
    ev_ls(32'h100, 32'h100, 1'b1); check("R4 fetch comparator ignores ls bus", {26'b0, wp_o}, 32'h00);
  endtask

  task automatic t_sign();
    do_reset();
    wr(5'h00, 32'h10); wr(5'h08, 32'h6); wr(5'h10, 32'h1);
    ev_if(32'hFFFF_FFF0, 1'b1); check("R5 address unsigned despite bit2", {26'b0, wp_o}, 32'h00);
    wr(5'h06, 32'h0); wr(5'h0E, 32'h6); wr(5'h13, 32'h1);
    ev_ls(32'h0, 32'hFFFF_FFFF, 1'b1); check("R5 R4 signed data LT", {26'b0, wp_o}, 32'h28);
    wr(5'h0E, 32'h2);
    ev_ls(32'h0, 32'hFFFF_FFFF, 1'b1); check("R5 unsigned data LT", {26'b0, wp_o}, 32'h00);
  endtask

  task automatic t_pairs();
    do_reset();
    wr(5'h04, 32'h1000); wr(5'h05, 32'h2000);
    wr(5'h0C, 32'h3); wr(5'h0D, 32'h2); wr(5'h12, 32'h2);
    ev_ls(32'h1800, 32'h0, 1'b1); check("R6 AND range inside", {26'b0, wp_o}, 32'h24);
    ev_ls(32'h2800, 32'h0, 1'b1); check("R6 AND range outside", {26'b0, wp_o}, 32'h00);
    wr(5'h0C, 32'h2); wr(5'h0D, 32'h3); wr(5'h12, 32'h3);
    ev_ls(32'h1800, 32'h0, 1'b1); check("R6 OR exclusion inside", {26'b0, wp_o}, 32'h00);
    ev_ls(32'h2800, 32'h0, 1'b1); check("R6 OR exclusion outside", {26'b0, wp_o}, 32'h24);
    wr(5'h06, 32'h55); wr(5'h0E, 32'h0); wr(5'h13, 32'h1);
    ev_ls(32'h2800, 32'h55, 1'b1); check("R7 addr and data", {26'b0, wp_o}, 32'h3C);
    ev_ls(32'h1800, 32'h55, 1'b1); check("R7 data only", {26'b0, wp_o}, 32'h28);
    wr(5'h12, 32'h0);
    ev_ls(32'h2800, 32'h0, 1'b1); check("R6 pair off", {26'b0, wp_o}, 32'h00);
  endtask

  task automatic t_valid();
    do_reset();
    wr(5'h00, 32'h0); wr(5'h10, 32'h1);
    wr(5'h04, 32'h0); wr(5'h12, 32'h1);
    ev_if(32'h0, 1'b0); check("R8 fetch not valid", {26'b0, wp_o}, 32'h00);
    ev_ls(32'h0, 32'h0, 1'b0); check("R8 ls not valid", {26'b0, wp_o}, 32'h00);
    ev_ls(32'h0, 32'h0, 1'b1); check("R8 ls valid", {26'b0, wp_o}, 32'h24);
  endtask

  task automatic t_b2b();
    do_reset();
    wr(5'h00, 32'h40); wr(5'h10, 32'h1);
    if_addr = 32'h40; if_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 back-to-back pulse", {26'b0, wp_o}, 32'h01);
    end
    if_valid = 1'b0;
    @(negedge clk);
    check("R9 pulse ends", {26'b0, wp_o}, 32'h00);
  endtask

  task automatic t_count();
    do_reset();
    wr(5'h00, 32'h40); wr(5'h10, 32'h1);
    wr(5'h18, 32'h0001_0003);
    for (int i = 1; i <= 6; i++) begin
      ev_if(32'h40, 1'b1);
      check("R10 every third event", {31'b0, bp_o[0]}, (i % 3 == 0) ? 32'h1 : 32'h0);
      ev_if(32'h40, 1'b0);
      check("R10 single-cycle pulse", {31'b0, bp_o[0]}, 32'h0);
    end
    wr(5'h18, 32'h0001_0000);
    for (int i = 0; i < 2; i++) begin
      ev_if(32'h40, 1'b1);
      check("R10 preset zero acts as one", {31'b0, bp_o[0]}, 32'h1);
    end
    wr(5'h18, 32'h0000_0001);
    for (int i = 0; i < 3; i++) begin
      ev_if(32'h40, 1'b1);
      check("R11 disabled counter", {26'b0, bp_o}, 32'h0);
    end
    wr(5'h18, 32'h0001_0003);
    ev_if(32'h40, 1'b1); ev_if(32'h40, 1'b1);
    wr(5'h18, 32'h0001_0003);
    ev_if(32'h40, 1'b1); check("R11 restart 1", {31'b0, bp_o[0]}, 32'h0);
    ev_if(32'h40, 1'b1); check("R11 restart 2", {31'b0, bp_o[0]}, 32'h0);
    ev_if(32'h40, 1'b1); check("R11 restart 3", {31'b0, bp_o[0]}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_cond();
    t_sign();
    t_pairs();
    t_valid();
    t_b2b();
    t_count();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule